// File: doc/BRIEF.md
# Timer-Paced Serial DAC Sample Streamer

This block is a serial master for a 16-bit voltage-output converter that is written one bit at a time. A free-running pace timer raises a sample tick every `sample_period + 1` clock cycles. Each tick that finds the block idle starts one transfer, so the output sample rate is set by the timer and not by software timing. The word for the transfer comes from a valid/ready input. If no word is offered, the previous word is sent again and a one-cycle underrun flag is raised.

During a transfer the active-low serial-enable line `dac_ser_n` is held low. The chip-select clock `dac_cs` toggles at a rate set by a programmable divider. Each bit is presented while `dac_cs` is low and is captured by the converter on the rising `dac_cs` edge. Bits go out MSB first. One bit-clock period after the frame closes, the load strobe `dac_ldac` rises. It stays high for exactly one bit-clock period, so all converters in a system update together and the load hold time is met.

The controller has four states:
- `ST_IDLE`: waits for a tick.
- `ST_SHIFT`: sends the 16 bits.
- `ST_GAP`: waits one bit period with the frame closed.
- `ST_LOAD`: holds the load strobe high.

It has four transitions:
- tick: `ST_IDLE` to `ST_SHIFT`.
- last-bit-done: `ST_SHIFT` to `ST_GAP`.
- gap-done: `ST_GAP` to `ST_LOAD`.
- load-done: `ST_LOAD` to `ST_IDLE`.

Top module: `dac_stream_tx`

## Requirements
- R1: While reset is held, and in the first cycle after it, the outputs are:
  - `dac_ser_n` is 1.
  - `dac_cs` is 0.
  - `dac_ldac` is 0.
  - `underrun` is 0.
  - `in_ready` is 0.
- R2: The pace timer ticks once every `sample_period + 1` clock cycles. With back-to-back frames, consecutive falling edges of `dac_ser_n` are exactly `sample_period + 1` cycles apart.
- R3: `in_ready` is 1 only in a cycle where a tick arrives while the block is idle. The word is captured only in a cycle where `in_valid` and `in_ready` are both 1. Changes on `in_data` at any other time do not alter the word sent.
- R4: A frame holds `dac_ser_n` low for exactly 32×(`half_div`+1) cycles. During that time `dac_cs` has exactly 16 rising edges, and the captured bits rebuild the word MSB first (bit 15 first).
- R5: `dac_cs` high and low phases each last `half_div + 1` cycles. `dac_sin` changes only while `dac_cs` is low or falling, so it is stable across every rising `dac_cs` edge.
- R6: `dac_ldac` rises exactly 2×(`half_div`+1) cycles after `dac_ser_n` rises. It is never 1 while `dac_ser_n` is 0.
- R7: `dac_ldac` stays 1 for exactly 2×(`half_div`+1) cycles, then returns to 0 before the next frame.
- R8: A tick with `in_valid` low still starts a frame. That frame resends the previously sent word, and `underrun` is 1 for exactly one cycle.
- R9: Ticks that arrive while a frame, gap or load phase is in progress are dropped. With `half_div` = 0 and `sample_period` = 9, the frame starts are 40 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_period | input | 16 | Tick period minus one, in clock cycles |
| half_div | input | 8 | Bit-clock half period minus one, in clock cycles |
| in_valid | input | 1 | Sample word offered |
| in_data | input | 16 | Sample word |
| in_ready | output | 1 | Word accepted this cycle when valid |
| dac_ser_n | output | 1 | Active-low serial-enable (frame) line |
| dac_cs | output | 1 | Chip-select bit clock; data captured on its rising edge |
| dac_sin | output | 1 | Serial data, MSB first |
| dac_ldac | output | 1 | Load strobe that moves the input latch to the output latch |
| underrun | output | 1 | One-cycle flag: no word was offered at a tick |

## Verification
The bench sends the words 0x8000 and 0x7FFF, where every bit flips between them. If the bit order were reversed, or the shift were off by one, these words would come back scrambled.

The bench measures two things on the load strobe:
- how many cycles it lags the end of the frame;
- how many cycles it stays high.

It does this at two divider settings. A strobe timed from the system clock instead of the bit clock would show a fixed delay that does not track `half_div`.

The bench withholds a word to check the resend path. A design that sent zero, or held `underrun` for longer than one cycle, would fail there.

The bench also sets a tick period shorter than a frame. A design that queued ticks, or started a frame while busy, would give a start-to-start interval other than 40 cycles.

// File: rtl/dac_stream_pkg.sv
package dac_stream_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2,
        ST_LOAD  = 2'd3
    } tx_state_t;

endpackage

// File: rtl/pace_timer.sv
module pace_timer #(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] period,
    output logic                tick
);

    logic [PERIOD_W-1:0] count_q;

    // The >= compare also covers the case where period is lowered below the current count.
    assign tick = (count_q >= period);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (tick) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + 1'b1;
        end
    end

endmodule

// File: rtl/half_period_div.sv
module half_period_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] half_div,
    output logic             strobe
);

    logic [DIV_W-1:0] hcount_q;

    assign strobe = en && (hcount_q == half_div);

    always_ff @(posedge clk) begin
        if (!rst_n || !en || strobe) begin
            hcount_q <= '0;
        end else begin
            hcount_q <= hcount_q + 1'b1;
        end
    end

endmodule

// File: rtl/dac_stream_tx.sv
module dac_stream_tx
    import dac_stream_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter int PERIOD_W = 16,
    parameter int DIV_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] sample_period,
    input  logic [DIV_W-1:0]    half_div,
    input  logic                in_valid,
    input  logic [WORD_W-1:0]   in_data,
    output logic                in_ready,
    output logic                dac_ser_n,
    output logic                dac_cs,
    output logic                dac_sin,
    output logic                dac_ldac,
    output logic                underrun
);

    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    tx_state_t         state_q, state_d;
    logic              tick;
    logic              strobe;
    logic [WORD_W-1:0] held_q;
    logic [WORD_W-1:0] shreg_q;
    logic [CNT_W-1:0]  bitcnt_q;
    logic              phase_q;
    logic              last_bit;
    logic [WORD_W-1:0] next_word;

    pace_timer #(.PERIOD_W(PERIOD_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .period (sample_period),
        .tick   (tick)
    );

    half_period_div #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (state_q != ST_IDLE),
        .half_div (half_div),
        .strobe   (strobe)
    );

    assign in_ready  = (state_q == ST_IDLE) && tick;
    assign last_bit  = (bitcnt_q == LAST_BIT);
    assign next_word = in_valid ? in_data : held_q;
    assign dac_sin   = shreg_q[WORD_W-1];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (tick)                             state_d = ST_SHIFT;
            ST_SHIFT: if (strobe && dac_cs && last_bit)     state_d = ST_GAP;
            ST_GAP:   if (strobe && phase_q)                state_d = ST_LOAD;
            ST_LOAD:  if (strobe && phase_q)                state_d = ST_IDLE;
            default:                                        state_d = ST_IDLE;
        endcase
    end

    // Outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q    <= '0;
            shreg_q   <= '0;
            bitcnt_q  <= '0;
            phase_q   <= 1'b0;
            dac_ser_n <= 1'b1;
            dac_cs    <= 1'b0;
            dac_ldac  <= 1'b0;
            underrun  <= 1'b0;
        end else begin
            underrun <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (tick) begin
                        held_q    <= next_word;
                        shreg_q   <= next_word;
                        bitcnt_q  <= '0;
                        phase_q   <= 1'b0;
                        dac_ser_n <= 1'b0;
                        dac_cs    <= 1'b0;
                        underrun  <= !in_valid;
                    end
                end
                ST_SHIFT: begin
                    if (strobe) begin
                        if (!dac_cs) begin
                            dac_cs <= 1'b1;
                        end else begin
                            dac_cs <= 1'b0;
                            if (last_bit) begin
                                dac_ser_n <= 1'b1;
                                phase_q   <= 1'b0;
                            end else begin
                                shreg_q  <= {shreg_q[WORD_W-2:0], 1'b0};
                                bitcnt_q <= bitcnt_q + 1'b1;
                            end
                        end
                    end
                end
                ST_GAP: begin
                    if (strobe) begin
                        phase_q <= !phase_q;
                        if (phase_q) dac_ldac <= 1'b1;
                    end
                end
                ST_LOAD: begin
                    if (strobe) begin
                        phase_q <= !phase_q;
                        if (phase_q) dac_ldac <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    // Assertions
    a_r6_ldac_outside_frame: assert property (@(posedge clk) disable iff (!rst_n)
        dac_ldac |-> dac_ser_n);

    a_r4_cs_rise_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_cs) |-> !dac_ser_n);

    a_r5_sin_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_cs) |-> $stable(dac_sin));

    a_r8_underrun_single: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> !underrun);

    a_r8_underrun_with_frame: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> !dac_ser_n);

    a_r3_accept_opens_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && in_valid) |=> !dac_ser_n);

    a_r9_no_start_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !dac_ser_n) |-> !in_ready);

endmodule

// File: tb/sim_dac_stream_tx.sv
module sim_dac_stream_tx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] sample_period = 16'd99;
    logic [7:0]  half_div = 8'd1;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = 16'h0000;
    logic        in_ready, dac_ser_n, dac_cs, dac_sin, dac_ldac, underrun;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    dac_stream_tx u0 (
        .clk(clk), .rst_n(rst_n), .sample_period(sample_period), .half_div(half_div),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .dac_ser_n(dac_ser_n), .dac_cs(dac_cs), .dac_sin(dac_sin),
        .dac_ldac(dac_ldac), .underrun(underrun)
    );

    // Monitor, sampled on falling clock edges
    int cyc = 0;
    logic p_ser_n = 1'b1, p_cs = 1'b0, p_sin = 1'b0, p_ldac = 1'b0, p_und = 1'b0;
    logic [15:0] shr = '0;
    int nbits = 0, t_start = 0, t_prev_start = 0, interval = 0;
    int t_end = 0, t_cs_rise = 0, t_ld = 0;
    int got_bits = 0, frame_len = 0, cs_hi_w = 0, ld_delay = 0, ld_w = 0;
    logic [15:0] got_word = '0;
    int frames = 0, stable_err = 0, und_ev = 0, und_cyc = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (p_ser_n && !dac_ser_n) begin
                shr = '0; nbits = 0;
                interval = cyc - t_prev_start;
                t_prev_start = cyc;
                t_start = cyc;
            end
            if (!dac_ser_n && !p_cs && dac_cs) begin
                shr = {shr[14:0], dac_sin};
                nbits++;
                t_cs_rise = cyc;
                if (dac_sin !== p_sin) stable_err++;
            end
            if (p_cs && !dac_cs) cs_hi_w = cyc - t_cs_rise;
            if (!p_ser_n && dac_ser_n) begin
                t_end = cyc; got_word = shr; got_bits = nbits; frame_len = cyc - t_start;
            end
            if (!p_ldac && dac_ldac) begin
                ld_delay = cyc - t_end; t_ld = cyc;
            end
            if (p_ldac && !dac_ldac) begin
                ld_w = cyc - t_ld; frames++;
            end
            if (underrun) und_cyc++;
            if (underrun && !p_und) und_ev++;
        end
        p_ser_n = dac_ser_n; p_cs = dac_cs; p_sin = dac_sin; p_ldac = dac_ldac; p_und = underrun;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
        end
    endtask

    task automatic push(input logic [15:0] w);
        bit ok = 0;
        in_data  = w;
        in_valid = 1'b1;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (in_ready) begin ok = 1; break; end
        end
        check("R3", "handshake seen", int'(ok), 1);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_frames(input int n);
        int target = frames + n;
        bit ok = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (frames >= target) begin ok = 1; break; end
        end
        check("R4", "frame completed in time", int'(ok), 1);
    endtask

    task automatic check_frame(input logic [15:0] w, input int h);
        check("R4", "word MSB first", int'(got_word), int'(w));
        check("R4", "bit count", got_bits, 16);
        check("R4", "frame length", frame_len, 32 * h);
        check("R5", "cs high width", cs_hi_w, h);
        check("R5", "sin stable at cs rise", stable_err, 0);
        check("R6", "ldac delay after frame", ld_delay, 2 * h);
        check("R7", "ldac high width", ld_w, 2 * h);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1", "ser_n in reset", int'(dac_ser_n), 1);
        check("R1", "cs in reset", int'(dac_cs), 0);
        check("R1", "ldac in reset", int'(dac_ldac), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "underrun after reset", int'(underrun), 0);
        check("R1", "in_ready after reset", int'(in_ready), 0);
        check("R1", "ser_n after reset", int'(dac_ser_n), 1);
    endtask

    task automatic t_stream();
        logic [15:0] words [4] = '{16'hA5C3, 16'h8000, 16'h7FFF, 16'hFFFF};
        wait_frames(1);
        for (int i = 0; i < 4; i++) begin
            push(words[i]);
            wait_frames(1);
            check_frame(words[i], 2);
            check("R2", "tick interval", interval, 100);
        end
    endtask

    task automatic t_ignore();
        push(16'h1234);
        in_data = 16'hDEAD;
        wait_frames(1);
        check("R3", "data changed off-handshake ignored", int'(got_word), 16'h1234);
        push(16'h0F0F);
        in_data = 16'hBEEF;
        wait_frames(1);
        check("R3", "second word captured at handshake", int'(got_word), 16'h0F0F);
    endtask

    task automatic t_underrun();
        int e0, c0;
        push(16'h3C5A);
        wait_frames(1);
        e0 = und_ev; c0 = und_cyc;
        wait_frames(1);
        check("R8", "repeated word", int'(got_word), 16'h3C5A);
        check("R8", "underrun events", und_ev - e0, 1);
        check("R8", "underrun cycles", und_cyc - c0, 1);
    endtask

    task automatic t_busy();
        wait_frames(1);
        half_div = 8'd0;
        sample_period = 16'd9;
        push(16'h0001);
        wait_frames(1);
        check_frame(16'h0001, 1);
        wait_frames(1);
        check("R9", "busy ticks dropped interval", interval, 40);
        check("R8", "underrun resends last word", int'(got_word), 16'h0001);
        wait_frames(1);
        half_div = 8'd3;
        sample_period = 16'd199;
        push(16'hC001);
        wait_frames(1);
        check_frame(16'hC001, 4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset();
        t_stream();
        t_ignore();
        t_underrun();
        t_busy();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule